// File: doc/BRIEF.md
# Load/Store Fetch-Execute Core

This block is a small multi-cycle processor built around a strict load/store discipline. Each instruction is one 32-bit word. The core reads that word from memory at the program counter into an instruction register. In a separate step it decodes the instruction register and carries out the operation. Only the two memory instructions touch data memory. The arithmetic instructions take their operands from a 32-entry register file, or take one operand from a sign-extended 16-bit immediate field in the instruction.

The core drives a single word-wide memory port: a byte address, a read strobe, a write strobe and write data. It accepts read data one clock after it raises the read strobe. Register R0 is wired to zero, so a move of a constant is written as an immediate add to R0. Two conditional branches are provided. One compares two registers as signed values and branches when the first is greater. The other tests one register for zero. Both add a signed byte offset to the address of the branch itself. An all-ones opcode stops the core and raises `halt` until the next reset.

Instruction word fields, from most to least significant: opcode [31:26], field A [25:21], field B [20:16], field C [15:11], immediate [15:0]. Opcodes:
- 0x01 ADD (A = B + C)
- 0x02 SUB (A = B - C)
- 0x03 ADDI (A = B + imm)
- 0x04 SUBI (A = B - imm)
- 0x05 LOAD (A = mem[B + imm])
- 0x06 STORE (mem[B + imm] = A)
- 0x07 BGT (branch if A > B, signed)
- 0x08 BEQZ (branch if A == 0)
- 0x3F HALT

Top module: `lsc_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the core presents a fetch: `mem_rd` = 1 and `mem_addr` = RESET_PC (default 0), with `mem_wr` = 0 and `halt` = 0.
- R2: Every instruction is fetched by one read strobe at the PC and then executed. ALU, store, branch and undefined instructions take 3 cycles. A load takes 4 cycles. The fields are opcode [31:26], A [25:21], B [20:16], C [15:11] and immediate [15:0].
- R3: After any instruction other than a taken branch or HALT, the PC advances by 4.
- R4: ADD (0x01) and SUB (0x02) write B+C or B−C into register A, modulo 2^32.
- R5: ADDI (0x03) and SUBI (0x04) sign-extend the 16-bit immediate to 32 bits, then write B+imm or B−imm into register A.
- R6: R0 always reads as zero. A write whose destination is R0 is discarded.
- R7: LOAD (0x05) raises one read strobe at byte address B + sext(imm) and writes the returned word into register A.
- R8: STORE (0x06) raises one write strobe at byte address B + sext(imm) carrying register A. No other instruction writes memory. `mem_rd` and `mem_wr` are never high together.
- R9: BGT (0x07) sets the PC to (branch address + sext(imm)) when register A is greater than register B as signed values. Otherwise the PC advances by 4. Equal operands do not branch.
- R10: BEQZ (0x08) sets the PC to (branch address + sext(imm)) when register A is zero. Otherwise the PC advances by 4. The offset may be negative.
- R11: Any other opcode except 0x3F changes no register, makes no data access and advances the PC by 4.
- R12: HALT (0x3F) raises `halt`. From then on the core raises no read or write strobe, and `halt` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | AW (32) | Byte address for fetch, load or store |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` the next cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | XLEN (32) | Store data |
| mem_rdata | input | XLEN (32) | Read data, one cycle after the read strobe |
| halt | output | 1 | High once a HALT instruction has executed |

## Verification
Short programs run on the core, and the results are read back from the data area the core stores into. Mixed-sign immediates and an all-ones load followed by an increment separate correct sign extension and wrap-around from a zero-extending or saturating datapath. Branches with operands (−1, 1), (1, −1) and (1, 1) separate a signed compare from an unsigned one, and a strict compare from greater-or-equal. A counted loop that ends on a zero test exercises backward and forward offsets, and its exact cycle and strobe counts expose any extra or missing step in the fetch/execute sequence. Undefined opcodes and writes to R0 are shown to have no effect through the values that are stored afterwards.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   localparam int unsigned IW    = 32;
   localparam int unsigned OPW   = 6;
   localparam int unsigned RIW   = 5;
   localparam int unsigned IMMW  = 16;
   localparam int unsigned OP_LSB = 26;
   localparam int unsigned A_LSB  = 21;
   localparam int unsigned B_LSB  = 16;
   localparam int unsigned C_LSB  = 11;

   localparam logic [OPW-1:0] OP_ADD   = 6'h01;
   localparam logic [OPW-1:0] OP_SUB   = 6'h02;
   localparam logic [OPW-1:0] OP_ADDI  = 6'h03;
   localparam logic [OPW-1:0] OP_SUBI  = 6'h04;
   localparam logic [OPW-1:0] OP_LOAD  = 6'h05;
   localparam logic [OPW-1:0] OP_STORE = 6'h06;
   localparam logic [OPW-1:0] OP_BGT   = 6'h07;
   localparam logic [OPW-1:0] OP_BEQZ  = 6'h08;
   localparam logic [OPW-1:0] OP_HALT  = 6'h3F;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_LATCH,
      ST_EXEC,
      ST_LOADWB,
      ST_HALTED
   } cstate_t;

   typedef enum logic [2:0] {
      K_NOP,
      K_ALU,
      K_LOAD,
      K_STORE,
      K_BGT,
      K_BEQZ,
      K_HALT
   } kind_t;

   typedef struct packed {
      kind_t            kind;
      logic             use_imm;
      logic             sub;
      logic [RIW-1:0]   dst;
      logic [RIW-1:0]   src1;
      logic [RIW-1:0]   src2;
      logic [IMMW-1:0]  imm;
   } dec_t;

endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
   import lsc_pkg::*;
(
   input  logic [IW-1:0] ir,
   output dec_t          dec
);

   logic [OPW-1:0] opc;
   logic [RIW-1:0] fa, fb, fc;

   assign opc = ir[OP_LSB +: OPW];
   assign fa  = ir[A_LSB +: RIW];
   assign fb  = ir[B_LSB +: RIW];
   assign fc  = ir[C_LSB +: RIW];

   always_comb begin
      dec.kind    = K_NOP;
      dec.use_imm = 1'b0;
      dec.sub     = 1'b0;
      dec.dst     = fa;
      dec.src1    = fb;
      dec.src2    = fc;
      dec.imm     = ir[IMMW-1:0];
      case (opc)
         OP_ADD:   dec.kind = K_ALU;
         OP_SUB: begin
            dec.kind = K_ALU;
            dec.sub  = 1'b1;
         end
         OP_ADDI: begin
            dec.kind    = K_ALU;
            dec.use_imm = 1'b1;
         end
         OP_SUBI: begin
            dec.kind    = K_ALU;
            dec.use_imm = 1'b1;
            dec.sub     = 1'b1;
         end
         OP_LOAD:  dec.kind = K_LOAD;
         OP_STORE: begin
            dec.kind = K_STORE;
            dec.src2 = fa;
         end
         OP_BGT: begin
            dec.kind = K_BGT;
            dec.src1 = fa;
            dec.src2 = fb;
         end
         OP_BEQZ: begin
            dec.kind = K_BEQZ;
            dec.src1 = fa;
         end
         OP_HALT:  dec.kind = K_HALT;
         default:  dec.kind = K_NOP;
      endcase
   end

endmodule

// File: rtl/lsc_alu.sv
module lsc_alu #(
   parameter int unsigned XLEN       = 32,
   parameter bit          SIGNED_CMP = 1'b1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            sub,
   output logic [XLEN-1:0] res,
   output logic            gt,
   output logic            a_zero
);

   assign res    = sub ? (a - b) : (a + b);
   assign a_zero = (a == '0);

   generate
      if (SIGNED_CMP) begin : g_scmp
         assign gt = ($signed(a) > $signed(b));
      end else begin : g_ucmp
         assign gt = (a > b);
      end
   endgenerate

endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
   parameter  int unsigned XLEN = 32,
   parameter  int unsigned NREG = 32,
   localparam int unsigned IDXW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [IDXW-1:0] waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [IDXW-1:0] raddr1,
   output logic [XLEN-1:0] rdata1,
   input  logic [IDXW-1:0] raddr2,
   output logic [XLEN-1:0] rdata2
);

   logic [NREG-1:0][XLEN-1:0] regs;

   generate
      if (NREG < 2) begin : g_bad_depth
         $error("lsc_regfile: NREG must be at least 2");
      end
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         if (g == 0) begin : g_zero
            assign regs[g] = '0;
         end else begin : g_flop
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
               if (rst) begin
                  q <= '0;
               end else if (we && (waddr == IDXW'(g))) begin
                  q <= wdata;
               end
            end
            assign regs[g] = q;
         end
      end
   endgenerate

   assign rdata1 = regs[raddr1];
   assign rdata2 = regs[raddr2];

   // R6: a write to a non-zero register is visible on the next cycle
   p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
      (we && (waddr != '0)) |=> (regs[$past(waddr)] == $past(wdata)));

   // R6: the zero register holds zero across writes aimed at it
   p_zero_kept_r6: assert property (@(posedge clk) disable iff (rst)
      (we && (waddr == '0)) |=> (rdata1 == '0 || raddr1 != '0));

endmodule

// File: rtl/lsc_core.sv
module lsc_core
   import lsc_pkg::*;
#(
   parameter int unsigned     XLEN       = 32,
   parameter int unsigned     AW         = 32,
   parameter int unsigned     NREG       = 32,
   parameter longint unsigned RESET_PC   = 0,
   parameter bit              SIGNED_CMP = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   output logic            halt
);

   localparam int unsigned STEP = IW / 8;

   generate
      if (XLEN < IW) begin : g_bad_xlen
         $error("lsc_core: XLEN must hold a full instruction word");
      end
      if (NREG != (1 << RIW)) begin : g_bad_nreg
         $error("lsc_core: NREG must match the register field width");
      end
      if (AW > XLEN) begin : g_bad_aw
         $error("lsc_core: AW must not exceed XLEN");
      end
      if ((RESET_PC % STEP) != 0) begin : g_bad_rpc
         $error("lsc_core: RESET_PC must be word aligned");
      end
   endgenerate

   cstate_t         state;
   logic [AW-1:0]   pc;
   logic [IW-1:0]   ir;
   dec_t            dec;

   logic [XLEN-1:0] rs1, rs2;
   logic [XLEN-1:0] imm_x;
   logic [XLEN-1:0] alu_b;
   logic [XLEN-1:0] alu_res;
   logic            alu_gt, alu_zero;
   logic [AW-1:0]   pc_seq, pc_br, ea;
   logic            take;
   logic            rf_we;
   logic [XLEN-1:0] rf_wdata;

   lsc_decode u_decode (
      .ir  (ir),
      .dec (dec)
   );

   lsc_regfile #(
      .XLEN (XLEN),
      .NREG (NREG)
   ) u_regfile (
      .clk    (clk),
      .rst    (rst),
      .we     (rf_we),
      .waddr  (dec.dst),
      .wdata  (rf_wdata),
      .raddr1 (dec.src1),
      .rdata1 (rs1),
      .raddr2 (dec.src2),
      .rdata2 (rs2)
   );

   assign imm_x = {{(XLEN-IMMW){dec.imm[IMMW-1]}}, dec.imm};
   assign alu_b = (dec.use_imm || dec.kind == K_LOAD || dec.kind == K_STORE) ? imm_x : rs2;

   lsc_alu #(
      .XLEN       (XLEN),
      .SIGNED_CMP (SIGNED_CMP)
   ) u_alu (
      .a      (rs1),
      .b      (alu_b),
      .sub    (dec.sub),
      .res    (alu_res),
      .gt     (alu_gt),
      .a_zero (alu_zero)
   );

   assign ea     = alu_res[AW-1:0];
   assign pc_seq = pc + AW'(STEP);
   assign pc_br  = pc + imm_x[AW-1:0];
   assign take   = (dec.kind == K_BGT && alu_gt) || (dec.kind == K_BEQZ && alu_zero);

   assign rf_we    = (state == ST_EXEC && dec.kind == K_ALU) || (state == ST_LOADWB);
   assign rf_wdata = (state == ST_LOADWB) ? mem_rdata : alu_res;

   assign mem_rd    = (state == ST_FETCH) || (state == ST_EXEC && dec.kind == K_LOAD);
   assign mem_wr    = (state == ST_EXEC && dec.kind == K_STORE);
   assign mem_addr  = (state == ST_FETCH) ? pc : ea;
   assign mem_wdata = rs2;
   assign halt      = (state == ST_HALTED);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_FETCH;
         pc    <= AW'(RESET_PC);
         ir    <= '0;
      end else begin
         case (state)
            ST_FETCH: state <= ST_LATCH;
            ST_LATCH: begin
               ir    <= mem_rdata[IW-1:0];
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               case (dec.kind)
                  K_LOAD: state <= ST_LOADWB;
                  K_HALT: state <= ST_HALTED;
                  K_BGT, K_BEQZ: begin
                     pc    <= take ? pc_br : pc_seq;
                     state <= ST_FETCH;
                  end
                  default: begin
                     pc    <= pc_seq;
                     state <= ST_FETCH;
                  end
               endcase
            end
            ST_LOADWB: begin
               pc    <= pc_seq;
               state <= ST_FETCH;
            end
            ST_HALTED: state <= ST_HALTED;
            default:   state <= ST_FETCH;
         endcase
      end
   end

   // R8: the port never reads and writes in the same cycle
   p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   // R12: once stopped, the core stays stopped
   p_halt_sticky_r12: assert property (@(posedge clk) disable iff (rst)
      halt |=> halt);

   // R12: a stopped core makes no memory access
   p_halt_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      halt |-> (!mem_rd && !mem_wr));

   // R3: an arithmetic instruction moves the PC by one word
   p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && dec.kind == K_ALU) |=> (pc == $past(pc) + AW'(STEP)));

   // R11: an undefined opcode only advances the PC and returns to fetch
   p_nop_skip_r11: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && dec.kind == K_NOP) |=>
         (state == ST_FETCH && pc == $past(pc) + AW'(STEP)));

   // R9: a taken compare branch lands on the offset target
   p_bgt_target_r9: assert property (@(posedge clk) disable iff (rst)
      (state == ST_EXEC && dec.kind == K_BGT && alu_gt) |=> (pc == $past(pc_br)));

   // R2: a fetch strobe is followed by the latch step
   p_fetch_seq_r2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |=> (state == ST_LATCH && !mem_rd && !mem_wr));

endmodule

// File: tb/lsc_core_bench.sv
module lsc_core_bench;

   localparam logic [5:0] K_ADD = 6'h01, K_SUB = 6'h02, K_ADDI = 6'h03, K_SUBI = 6'h04,
                          K_LD = 6'h05, K_ST = 6'h06, K_BGT = 6'h07, K_BEQZ = 6'h08,
                          K_HLT = 6'h3F;

   logic        clk;
   logic        rst;
   logic [31:0] mem_addr;
   logic        mem_rd;
   logic        mem_wr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        halt;

   logic [31:0] mem [256];
   int          vectors = 0;
   int          fails   = 0;
   int          rd_cnt;
   int          wr_cnt;

   lsc_core u_lsc_core (
      .clk       (clk),
      .rst       (rst),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .halt      (halt)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
      if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
   end

   always @(posedge clk) begin
      if (rst) begin
         rd_cnt <= 0;
         wr_cnt <= 0;
      end else begin
         if (mem_rd) rd_cnt <= rd_cnt + 1;
         if (mem_wr) wr_cnt <= wr_cnt + 1;
      end
   end

   function automatic logic [31:0] rr(logic [5:0] op, int a, int b, int c);
      return {op, a[4:0], b[4:0], c[4:0], 11'b0};
   endfunction

   function automatic logic [31:0] ri(logic [5:0] op, int a, int b, int imm);
      return {op, a[4:0], b[4:0], imm[15:0]};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 32'h0;
   endtask

   task automatic run(input int limit, output int cyc);
      repeat (2) @(negedge clk);
      rst = 1'b0;
      cyc = 0;
      while (!halt && cyc < limit) begin
         @(negedge clk);
         cyc++;
      end
      if (!halt) begin
         vectors++;
         fails++;
         $display("FAIL R12 program did not halt: got running expected halt");
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      clear_mem();
      repeat (2) @(negedge clk);
      check("R1", "halt in reset", 32'(halt), 32'd0);
      check("R1", "write strobe in reset", 32'(mem_wr), 32'd0);
      check("R1", "fetch strobe in reset", 32'(mem_rd), 32'd1);
      check("R1", "fetch address in reset", mem_addr, 32'h0);
      rst = 1'b0;
      @(negedge clk);
      rst = 1'b1;
   endtask

   task automatic t_alu();
      int cyc;
      rst = 1'b1;
      clear_mem();
      mem[0]  = ri(K_ADDI, 1, 0, 100);
      mem[1]  = ri(K_ADDI, 2, 0, -7);
      mem[2]  = rr(K_ADD, 3, 1, 2);
      mem[3]  = rr(K_SUB, 4, 2, 1);
      mem[4]  = ri(K_SUBI, 5, 1, -5);
      mem[5]  = ri(K_LD, 6, 0, 'h280);
      mem[6]  = ri(K_ADDI, 7, 6, 1);
      mem[7]  = ri(K_ST, 3, 0, 'h200);
      mem[8]  = ri(K_ST, 4, 0, 'h204);
      mem[9]  = ri(K_ST, 5, 0, 'h208);
      mem[10] = ri(K_ST, 7, 0, 'h20C);
      mem[11] = ri(K_ST, 2, 0, 'h210);
      mem[12] = {K_HLT, 26'h0};
      mem[160] = 32'hFFFF_FFFF;
      run(200, cyc);
      check("R4", "ADD 100+(-7)", mem[128], 32'd93);
      check("R4", "SUB -7-100", mem[129], 32'hFFFF_FF95);
      check("R5", "SUBI 100-(-5)", mem[130], 32'd105);
      check("R4", "wrap of all-ones plus one", mem[131], 32'h0);
      check("R5", "negative immediate sign-extended", mem[132], 32'hFFFF_FFF9);
      check("R2", "cycles for 12 ops and one load", 32'(cyc), 32'd40);
      check("R8", "read strobes", 32'(rd_cnt), 32'd14);
      check("R8", "write strobes", 32'(wr_cnt), 32'd5);
   endtask

   task automatic t_zero();
      int cyc;
      rst = 1'b1;
      clear_mem();
      mem[0] = ri(K_ADDI, 0, 0, 55);
      mem[1] = ri(K_ST, 0, 0, 'h200);
      mem[2] = ri(K_SUBI, 3, 0, 1);
      mem[3] = ri(K_ST, 3, 0, 'h204);
      mem[4] = {K_HLT, 26'h0};
      mem[128] = 32'hDEAD_BEEF;
      run(200, cyc);
      check("R6", "R0 after write of 55", mem[128], 32'h0);
      check("R6", "R0 minus one", mem[129], 32'hFFFF_FFFF);
   endtask

   task automatic t_ldst();
      int cyc;
      rst = 1'b1;
      clear_mem();
      mem[0] = ri(K_ADDI, 1, 0, 'h220);
      mem[1] = ri(K_LD, 2, 1, -8);
      mem[2] = ri(K_LD, 3, 1, 4);
      mem[3] = rr(K_ADD, 4, 2, 3);
      mem[4] = ri(K_ST, 4, 1, -4);
      mem[5] = ri(K_ST, 2, 1, 'h10);
      mem[6] = {K_HLT, 26'h0};
      mem[134] = 32'h1234_5678;
      mem[137] = 32'h0000_0011;
      mem[136] = 32'hA5A5_A5A5;
      run(200, cyc);
      check("R7", "loads with negative and positive offsets", mem[135], 32'h1234_5689);
      check("R8", "store at base plus offset", mem[140], 32'h1234_5678);
      check("R8", "untouched word at base", mem[136], 32'hA5A5_A5A5);
      check("R8", "write strobe count", 32'(wr_cnt), 32'd2);
      check("R7", "read strobe count", 32'(rd_cnt), 32'd9);
      check("R2", "cycles with two loads", 32'(cyc), 32'd23);
   endtask

   task automatic t_bgt();
      int cyc;
      rst = 1'b1;
      clear_mem();
      mem[0]  = ri(K_ADDI, 1, 0, -1);
      mem[1]  = ri(K_ADDI, 2, 0, 1);
      mem[2]  = ri(K_BGT, 1, 2, 8);
      mem[3]  = ri(K_ADDI, 3, 0, 11);
      mem[4]  = ri(K_BGT, 2, 1, 8);
      mem[5]  = ri(K_ADDI, 4, 0, 22);
      mem[6]  = ri(K_BGT, 2, 2, 8);
      mem[7]  = ri(K_ADDI, 5, 0, 33);
      mem[8]  = ri(K_ST, 3, 0, 'h200);
      mem[9]  = ri(K_ST, 4, 0, 'h204);
      mem[10] = ri(K_ST, 5, 0, 'h208);
      mem[11] = {K_HLT, 26'h0};
      run(200, cyc);
      check("R9", "-1 > 1 not taken (signed)", mem[128], 32'd11);
      check("R9", "1 > -1 taken, skip", mem[129], 32'd0);
      check("R9", "equal not taken", mem[130], 32'd33);
      check("R3", "cycles over eleven instructions", 32'(cyc), 32'd33);
   endtask

   task automatic t_loop();
      int cyc;
      rst = 1'b1;
      clear_mem();
      mem[0]  = ri(K_ADDI, 2, 0, 3);
      mem[1]  = ri(K_ADDI, 4, 0, 'h280);
      mem[2]  = rr(K_ADD, 3, 0, 0);
      mem[3]  = ri(K_BEQZ, 2, 0, 24);
      mem[4]  = ri(K_LD, 5, 4, 0);
      mem[5]  = rr(K_ADD, 3, 3, 5);
      mem[6]  = ri(K_ADDI, 4, 4, 4);
      mem[7]  = ri(K_SUBI, 2, 2, 1);
      mem[8]  = ri(K_BEQZ, 0, 0, -20);
      mem[9]  = ri(K_ST, 3, 0, 'h300);
      mem[10] = {K_HLT, 26'h0};
      mem[160] = 32'd10;
      mem[161] = 32'd20;
      mem[162] = 32'd30;
      run(400, cyc);
      check("R10", "loop sum", mem[192], 32'd60);
      check("R10", "cycles of counted loop", 32'(cyc), 32'd75);
      check("R3", "read strobes in loop", 32'(rd_cnt), 32'd27);
      check("R8", "single store in loop", 32'(wr_cnt), 32'd1);
   endtask

   task automatic t_undef();
      int cyc;
      rst = 1'b1;
      clear_mem();
      mem[0] = ri(K_ADDI, 1, 0, 9);
      mem[1] = ri(6'h15, 1, 0, 5);
      mem[2] = rr(6'h00, 1, 1, 1);
      mem[3] = ri(K_ST, 1, 0, 'h200);
      mem[4] = {K_HLT, 26'h0};
      run(200, cyc);
      check("R11", "register kept over undefined opcodes", mem[128], 32'd9);
      check("R11", "no extra data access", 32'(rd_cnt + wr_cnt), 32'd6);
      check("R11", "cycles with undefined opcodes", 32'(cyc), 32'd15);
   endtask

   task automatic t_halt();
      int cyc;
      rst = 1'b1;
      clear_mem();
      mem[0] = {K_HLT, 26'h0};
      mem[1] = ri(K_ST, 0, 0, 'h200);
      mem[128] = 32'h5555_AAAA;
      run(50, cyc);
      check("R12", "cycles to halt", 32'(cyc), 32'd3);
      repeat (20) @(negedge clk);
      check("R12", "halt stays high", 32'(halt), 32'd1);
      check("R12", "no fetch after halt", 32'(rd_cnt), 32'd1);
      check("R12", "no store after halt", 32'(wr_cnt), 32'd0);
      check("R12", "memory untouched", mem[128], 32'h5555_AAAA);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      vectors++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      rst = 1'b1;
      t_reset();
      t_alu();
      t_zero();
      t_ldst();
      t_bgt();
      t_loop();
      t_undef();
      t_halt();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule